// File: doc/BRIEF.md
# Distributed-Arithmetic Four-Tap Inner Product Unit

This unit forms the dot product of four programmable signed coefficients with four signed samples. Multipliers are not used. Every sum of a subset of the coefficients is held in a sixteen-entry table, and the product is built one bit plane at a time. At each plane, the bits of the four samples at that position make up the table address. The table entry it selects is folded into a running accumulator. One plane costs one cycle, so the precision of the result is a per-operation choice rather than a fixed property of the hardware.

When a start strobe arrives, the unit measures the smallest two's-complement width that holds all four samples. Planes above that width only repeat the sign, and the unit does not spend cycles on them. An optional plane cap bounds the work further by dropping the least significant planes. Small or correlated inputs therefore finish in few cycles, and the cap trades accuracy for switching activity. The result is presented with a single-cycle valid pulse. Latency depends on the data.

Top module: `da_inner_product`

## Requirements
- R1: After a synchronous active-low reset, `valid_o` and `busy_o` are 0, `result_o` is 0 and all four coefficients are 0.
- R2: With no cap in effect, `result_o` equals A0*x0 + A1*x1 + A2*x2 + A3*x3 taken modulo 2^24. Here xi is the two's-complement sample in bits [12i+11:12i] of `samples_i`.
- R3: A cycle with `coef_we_i` high while idle loads `coef_data_i` as coefficient A`coef_sel_i` (0 to 3). The four coefficients rebuild the table so that, at every plane, sample i selects A(i) through address bit i.
- R4: The active plane count P is the smallest width from 1 to 12 in which every sample fits as a two's-complement number. With no cap, `valid_o` rises exactly P clock edges after the edge that accepted the start.
- R5: A `cap_i` of 0, or a cap of at least P, imposes no limit. Otherwise only the top `cap_i` planes are processed, `valid_o` rises `cap_i` edges after the start, and the result equals the sum of Ai*(xi with its lowest P-`cap_i` bits cleared).
- R6: `valid_o` is high for exactly one cycle per operation. `result_o` holds its value until the next operation completes.
- R7: `busy_o` is high from the edge that accepts a start up to the edge that raises `valid_o`. A start strobe seen while busy is ignored and produces no further result.
- R8: A coefficient write presented while busy is discarded.
- R9: Samples and cap are captured when the start is accepted. Changes to these inputs during an operation do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_sel_i | input | 2 | Coefficient index for the write |
| coef_data_i | input | 12 | Signed coefficient value |
| cap_i | input | 4 | Maximum planes per operation, 0 means unlimited |
| start_i | input | 1 | Start strobe, accepted while idle |
| samples_i | input | 48 | Four signed 12-bit samples, sample i in bits [12i+11:12i] |
| busy_o | output | 1 | Operation in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 24 | Signed inner product |

## Verification
The assertions assume that reset is applied long enough to clear the registers, and that `cap_i` and the samples are stable only at the edge that accepts a start. They also assume that `start_i` may be held during a run without meaning anything. The stimulus writes coefficients only while the unit is idle, except in one deliberate case that checks R8. It also drives unrelated values onto the samples and the cap during every run and pushes a stray start into one operation. The random samples are drawn as values sign-extended from a random width between 1 and 12 bits. This spreads P across its full range, and the random caps from 0 to 15 cover the unlimited, equal-to-P and truncating cases alike.

// File: rtl/da_pkg.sv
// Package: shared types and helpers for the distributed-arithmetic unit.
// Assumes only that clients agree on the two-state sequencer encoding.
package da_pkg;

    // Sequencer state of the read-accumulate loop
    typedef enum logic {
        RAC_IDLE = 1'b0,
        RAC_RUN  = 1'b1
    } rac_state_e;

endpackage

// File: rtl/da_coef_table.sv
// Module: coefficient register file and subset-sum table.
// Holds N_TAPS signed coefficients. Entry k of the table holds the sum of
// the coefficients whose index bit is set in k. The entries are rebuilt in
// the same edge that writes a coefficient, so the table never lags the
// coefficients. Assumes the caller gates writes (the top blocks them while busy).
module da_coef_table #(
    parameter int N_TAPS = 4,
    parameter int COEF_W = 12,
    parameter int TW     = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [$clog2(N_TAPS)-1:0] wr_sel_i,
    input  logic [COEF_W-1:0]         wr_data_i,
    input  logic [N_TAPS-1:0]         rd_addr_i,
    output logic [TW-1:0]             rd_data_o
);
    localparam int ENTRIES = 1 << N_TAPS;

    logic [N_TAPS-1:0][COEF_W-1:0] coef_q;
    logic [N_TAPS-1:0][COEF_W-1:0] coef_nx;
    logic [ENTRIES-1:0][TW-1:0]    tbl_q;
    logic [ENTRIES-1:0][TW-1:0]    sum_w;

    // Next coefficient set: current set with the addressed one replaced
    always_comb begin
        coef_nx = coef_q;
        if (wr_en_i) coef_nx[wr_sel_i] = wr_data_i;
    end

    // Coefficient registers
    always_ff @(posedge clk) begin
        if (!rst_n) coef_q <= '0;
        else        coef_q <= coef_nx;
    end

    genvar k;
    generate
        for (k = 0; k < ENTRIES; k++) begin : g_entry
            localparam logic [N_TAPS-1:0] PICK = N_TAPS'(k);

            // Subset sum selected by this entry's index bits
            always_comb begin
                logic [TW-1:0] acc;
                acc = '0;
                for (int i = 0; i < N_TAPS; i++) begin
                    if (PICK[i])
                        acc = acc + {{(TW-COEF_W){coef_nx[i][COEF_W-1]}}, coef_nx[i]};
                end
                sum_w[k] = acc;
            end

            // Table entry register
            always_ff @(posedge clk) begin
                if (!rst_n) tbl_q[k] <= '0;
                else        tbl_q[k] <= sum_w[k];
            end
        end
    endgenerate

    // Table read port, combinational
    assign rd_data_o = tbl_q[rd_addr_i];

    AST_EMPTY_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_q[0] == '0); // R3

    genvar t;
    generate
        for (t = 0; t < N_TAPS; t++) begin : g_chk
            AST_SINGLE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
                tbl_q[1 << t] == {{(TW-COEF_W){coef_q[t][COEF_W-1]}}, coef_q[t]}); // R3
        end
    endgenerate

endmodule

// File: rtl/da_plane_detect.sv
// Module: active bit-plane detector.
// Finds the smallest two's-complement width (1..IN_W) that holds every
// sample. A bit below the sign that differs from the sign marks a plane that
// carries information. Purely combinational.
module da_plane_detect #(
    parameter int N_TAPS = 4,
    parameter int IN_W   = 12,
    parameter int PW     = 4
) (
    input  logic [N_TAPS*IN_W-1:0] samples_i,
    output logic [PW-1:0]          planes_o
);
    logic [IN_W-2:0] diff_w;

    // Merge, over all taps, the bits that differ from their sample's sign
    always_comb begin
        diff_w = '0;
        for (int i = 0; i < N_TAPS; i++) begin
            diff_w = diff_w | (samples_i[i*IN_W +: IN_W-1]
                             ^ {(IN_W-1){samples_i[i*IN_W + IN_W-1]}});
        end
    end

    // Highest informative bit plus one sign bit gives the width
    always_comb begin
        planes_o = PW'(1);
        for (int b = 0; b < IN_W-1; b++) begin
            if (diff_w[b]) planes_o = PW'(b + 2);
        end
    end

endmodule

// File: rtl/da_rac_engine.sv
// Module: read-accumulate sequencer.
// On an accepted start, it captures the samples and computes the effective
// plane count from the detected width and the cap. It then walks the planes
// from the sign plane downwards: the sign plane's table entry is subtracted
// and each later plane doubles the accumulator and adds its entry. At the
// last plane, the sum is scaled back by the dropped planes and the result
// strobe is raised. Assumes planes_i is in 1..IN_W.
module da_rac_engine
    import da_pkg::*;
#(
    parameter int N_TAPS = 4,
    parameter int IN_W   = 12,
    parameter int TW     = 14,
    parameter int OUT_W  = 24,
    parameter int PW     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [N_TAPS*IN_W-1:0] samples_i,
    input  logic [PW-1:0]          planes_i,
    input  logic [PW-1:0]          cap_i,
    input  logic [TW-1:0]          tbl_data_i,
    output logic [N_TAPS-1:0]      tbl_addr_o,
    output logic                   busy_o,
    output logic                   valid_o,
    output logic [OUT_W-1:0]       result_o
);
    rac_state_e                  state_q;
    logic [N_TAPS-1:0][IN_W-1:0] samp_q;
    logic [PW-1:0]               plane_q;
    logic [PW-1:0]               left_q;
    logic [PW-1:0]               shift_q;
    logic                        first_q;
    logic [OUT_W-1:0]            acc_q;
    logic [OUT_W-1:0]            res_q;
    logic                        vld_q;
    logic [PW-1:0]               eff_w;
    logic [OUT_W-1:0]            ent_w;
    logic [OUT_W-1:0]            nxt_w;
    logic [PW-1:0]               run_cnt_q;
    logic [PW-1:0]               cap_q;

    // Planes to run: the detected width, or the cap when it is tighter
    always_comb begin
        if (cap_i == '0 || cap_i >= planes_i) eff_w = planes_i;
        else                                  eff_w = cap_i;
    end

    // Gather the current plane's bit from each captured sample
    genvar i;
    generate
        for (i = 0; i < N_TAPS; i++) begin : g_addr
            assign tbl_addr_o[i] = samp_q[i][plane_q];
        end
    endgenerate

    // Sign-extended table entry and next accumulator value
    always_comb begin
        ent_w = {{(OUT_W-TW){tbl_data_i[TW-1]}}, tbl_data_i};
        if (first_q) nxt_w = '0 - ent_w;
        else         nxt_w = (acc_q << 1) + ent_w;
    end

    // Sequencer, accumulator and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RAC_IDLE;
            samp_q  <= '0;
            plane_q <= '0;
            left_q  <= '0;
            shift_q <= '0;
            first_q <= 1'b0;
            acc_q   <= '0;
            res_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            case (state_q)
                RAC_IDLE: begin
                    if (start_i) begin
                        samp_q  <= samples_i;
                        plane_q <= planes_i - PW'(1);
                        left_q  <= eff_w;
                        shift_q <= planes_i - eff_w;
                        first_q <= 1'b1;
                        acc_q   <= '0;
                        state_q <= RAC_RUN;
                    end
                end
                RAC_RUN: begin
                    acc_q   <= nxt_w;
                    plane_q <= plane_q - PW'(1);
                    left_q  <= left_q - PW'(1);
                    first_q <= 1'b0;
                    if (left_q == PW'(1)) begin
                        res_q   <= nxt_w << shift_q;
                        vld_q   <= 1'b1;
                        state_q <= RAC_IDLE;
                    end
                end
                default: state_q <= RAC_IDLE;
            endcase
        end
    end

    // Run-length counter and captured cap, kept for the assertions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt_q <= '0;
            cap_q     <= '0;
        end else if (state_q == RAC_RUN) begin
            run_cnt_q <= run_cnt_q + PW'(1);
        end else if (start_i) begin
            run_cnt_q <= '0;
            cap_q     <= cap_i;
        end
    end

    assign busy_o   = (state_q == RAC_RUN);
    assign valid_o  = vld_q;
    assign result_o = res_q;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q); // R6
    AST_IDLE_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> state_q == RAC_IDLE); // R7
    AST_PLANE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RAC_RUN && left_q > PW'(1)) |=>
        (state_q == RAC_RUN && left_q == $past(left_q) - PW'(1))); // R4
    AST_CAP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && cap_q != '0) |-> run_cnt_q <= cap_q); // R5
    AST_RUN_LENGTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (run_cnt_q >= PW'(1) && run_cnt_q <= PW'(IN_W))); // R4

endmodule

// File: rtl/da_inner_product.sv
// Module: top of the distributed-arithmetic inner product unit.
// Connects the coefficient table, the plane detector and the read-accumulate
// engine, and blocks coefficient writes while an operation is in flight.
// Assumes the table entry width covers the sum of all four coefficients.
module da_inner_product #(
    parameter int N_TAPS = 4,
    parameter int IN_W   = 12,
    parameter int COEF_W = 12,
    parameter int OUT_W  = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      coef_we_i,
    input  logic [$clog2(N_TAPS)-1:0] coef_sel_i,
    input  logic [COEF_W-1:0]         coef_data_i,
    input  logic [$clog2(IN_W+1)-1:0] cap_i,
    input  logic                      start_i,
    input  logic [N_TAPS*IN_W-1:0]    samples_i,
    output logic                      busy_o,
    output logic                      valid_o,
    output logic [OUT_W-1:0]          result_o
);
    localparam int PW = $clog2(IN_W + 1);
    localparam int TW = COEF_W + $clog2(N_TAPS);

    logic              tbl_we_w;
    logic [N_TAPS-1:0] tbl_addr_w;
    logic [TW-1:0]     tbl_data_w;
    logic [PW-1:0]     planes_w;

    // Coefficient writes only take effect while idle
    assign tbl_we_w = coef_we_i && !busy_o;

    da_coef_table #(
        .N_TAPS (N_TAPS),
        .COEF_W (COEF_W),
        .TW     (TW)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (tbl_we_w),
        .wr_sel_i  (coef_sel_i),
        .wr_data_i (coef_data_i),
        .rd_addr_i (tbl_addr_w),
        .rd_data_o (tbl_data_w)
    );

    da_plane_detect #(
        .N_TAPS (N_TAPS),
        .IN_W   (IN_W),
        .PW     (PW)
    ) u_detect (
        .samples_i (samples_i),
        .planes_o  (planes_w)
    );

    da_rac_engine #(
        .N_TAPS (N_TAPS),
        .IN_W   (IN_W),
        .TW     (TW),
        .OUT_W  (OUT_W),
        .PW     (PW)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .samples_i  (samples_i),
        .planes_i   (planes_w),
        .cap_i      (cap_i),
        .tbl_data_i (tbl_data_w),
        .tbl_addr_o (tbl_addr_w),
        .busy_o     (busy_o),
        .valid_o    (valid_o),
        .result_o   (result_o)
    );

    AST_BUSY_ENDS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> valid_o); // R7
    AST_PLANES_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (planes_w >= PW'(1) && planes_w <= PW'(IN_W))); // R4

endmodule

// File: tb/da_inner_product_tb.sv
// Bench: directed corner cases plus seeded random operations, checked
// against a bench model of the plane-truncated inner product.
module da_inner_product_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coef_we = 1'b0;
    logic [1:0]  coef_sel = '0;
    logic [11:0] coef_data = '0;
    logic [3:0]  cap = '0;
    logic        start = 1'b0;
    logic [47:0] samples = '0;
    logic        busy;
    logic        valid;
    logic [23:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int coefs[4];

    always #10 clk = ~clk;

    da_inner_product dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .coef_we_i   (coef_we),
        .coef_sel_i  (coef_sel),
        .coef_data_i (coef_data),
        .cap_i       (cap),
        .start_i     (start),
        .samples_i   (samples),
        .busy_o      (busy),
        .valid_o     (valid),
        .result_o    (result)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int plane_count(input int x[4]);
        int p = 1;
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < 11; k++)
                if (((x[i] >>> k) & 1) != ((x[i] < 0) ? 1 : 0) && k + 2 > p) p = k + 2;
        return p;
    endfunction

    function automatic int eff_planes(input int x[4], input int c);
        int p = plane_count(x);
        return (c == 0 || c >= p) ? p : c;
    endfunction

    function automatic logic [23:0] model(input int x[4], input int c);
        int p = plane_count(x);
        int l = p - eff_planes(x, c);
        longint s = 0;
        for (int i = 0; i < 4; i++)
            s += longint'(coefs[i]) * longint'((x[i] >>> l) <<< l);
        return s[23:0];
    endfunction

    function automatic int rnd_sample();
        int w = 1 + int'($urandom % 12);
        int v = int'($urandom);
        return (v <<< (32 - w)) >>> (32 - w);
    endfunction

    task automatic write_coef(input int idx, input int val);
        @(negedge clk);
        coef_we   = 1'b1;
        coef_sel  = 2'(idx);
        coef_data = 12'(val);
        coefs[idx] = ((val <<< 20) >>> 20);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    function automatic logic [47:0] pack(input int x[4]);
        logic [47:0] v;
        for (int i = 0; i < 4; i++) v[i*12 +: 12] = 12'(x[i]);
        return v;
    endfunction

    // One operation; R4/R5 latency, R2/R5 value, R7 busy, R9 inputs scrambled mid-run
    task automatic run_op(input int x[4], input int c, input string req);
        int n;
        int e = eff_planes(x, c);
        logic [23:0] exp = model(x, c);
        @(negedge clk);
        samples = pack(x);
        cap     = 4'(c);
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start   = 1'b0;
        samples = {$urandom, $urandom};
        cap     = 4'($urandom);
        check(busy === 1'b1, "R7 busy after start", busy, 1);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!valid && n < 20);
        check(n == e, {req, " latency"}, n, e);
        check(result === exp, {req, " result"}, result, exp);
        check(busy === 1'b0, "R7 idle at valid", busy, 0);
        @(negedge clk);
        check(valid === 1'b0, "R6 single pulse", valid, 0);
        check(result === exp, "R6 result held", result, exp);
    endtask

    initial begin
        int x[4];
        void'($urandom(32'h5EED_0D1A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(valid === 1'b0, "R1 valid", valid, 0);
        check(busy === 1'b0, "R1 busy", busy, 0);
        check(result === 24'd0, "R1 result", result, 0);
        coefs = '{0, 0, 0, 0};
        x = '{1234, -7, 99, -2048};
        run_op(x, 0, "R1 zero coefficients");

        // R3 coefficient loading and tap mapping
        write_coef(0, 3); write_coef(1, -5); write_coef(2, 7); write_coef(3, -11);
        x = '{5, 0, 0, 0};    run_op(x, 0, "R3 tap0");
        x = '{0, 0, 0, -300}; run_op(x, 0, "R3 tap3");
        x = '{0, 9, -9, 0};   run_op(x, 0, "R3 tap1/2");
        // R4 minimum width corners
        x = '{0, 0, 0, 0};    run_op(x, 0, "R4 all zero");
        x = '{-1, -1, -1, -1}; run_op(x, 0, "R4 all minus one");
        x = '{2047, -2048, 1, 0}; run_op(x, 0, "R4 full width");
        // R2 wraparound corner
        write_coef(0, -2048); write_coef(1, -2048); write_coef(2, -2048); write_coef(3, -2048);
        x = '{-2048, -2048, -2048, -2048}; run_op(x, 0, "R2 wrap");
        x = '{2047, 2047, 2047, 2047};     run_op(x, 0, "R2 max positive");
        // R5 cap cases
        write_coef(0, 123); write_coef(1, -456); write_coef(2, 789); write_coef(3, -1000);
        x = '{1500, -900, 333, -1};
        run_op(x, 1, "R5 cap one");
        run_op(x, 5, "R5 cap five");
        run_op(x, 12, "R5 cap equal");
        run_op(x, 15, "R5 cap above");

        // R7/R8: stray start and coefficient write during a run are ignored
        begin
            logic [23:0] exp;
            int n;
            x = '{-1900, 1800, 5, 77};
            exp = model(x, 0);
            @(negedge clk);
            samples = pack(x); cap = 4'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            start = 1'b1; samples = {$urandom, $urandom};
            coef_we = 1'b1; coef_sel = 2'd2; coef_data = 12'd999;
            @(negedge clk);
            start = 1'b0; coef_we = 1'b0;
            n = 0;
            while (!valid && n < 20) begin @(negedge clk); n++; end
            check(result === exp, "R8 write during run", result, exp);
            n = 0;
            repeat (15) begin @(negedge clk); if (valid) n++; end
            check(n == 0, "R7 stray start ignored", n, 0);
            run_op(x, 0, "R8 coefficient unchanged");
        end

        // Random operations (R2, R4, R5, R9)
        for (int t = 0; t < 300; t++) begin
            if (t % 25 == 0)
                for (int i = 0; i < 4; i++) write_coef(i, int'($urandom % 4096) - 2048);
            for (int i = 0; i < 4; i++) x[i] = rnd_sample();
            run_op(x, int'($urandom % 16), "R2/R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule